// File: doc/BRIEF.md
# Pretrigger Circular Capture Buffer

This block records a bank of single-bit digital channels into on-chip memory so that a stretch of activity around an event can be examined afterwards. All channels are sampled together on each rising clock edge, and one word holding every channel goes into a circular store. Until a trigger arrives, the store keeps being overwritten, so it always holds the most recent history. Once triggered, the block writes a programmed number of further words and then freezes the record.

A pre-trigger length chosen at arm time sets how many of the record's words come before the trigger sample. Setting it to half the depth places the event in the middle of the record. A frozen record is read out one word per read request, oldest word first. In single mode the block then waits for a new arm command. In normal mode it starts a fresh acquisition by itself once the whole record has been read.

Top module: `cap_buffer`

## Requirements
- R1: While reset is asserted and after it is released, status is 0 (idle), done is low and read-valid is low, until an arm command arrives.
- R2: In the fill, armed and post states, exactly one word holding all channels, as sampled at that rising edge, is written per clock. Writes go to consecutive addresses and wrap round the memory, overwriting the oldest word.
- R3: A trigger is ignored until pre-trigger-length words have been written since arming. During fill (status 1) a trigger never moves the block to post or done.
- R4: A trigger seen in the armed state (status 2) makes its own sample the first of DEPTH minus pre-trigger-length post-trigger writes. The record then freezes, and no write happens while it is frozen. If that count is 1, the block goes directly from armed to done.
- R5: The trigger address output holds the memory address of the trigger sample. Addresses start at 0 on the first write after arming or restart.
- R6: While frozen, done is high. Each read request returns one word, with read-valid high on the following cycle. The DEPTH words come back in time order: pre-trigger-length words before the trigger sample, then the trigger sample, then the words after it.
- R7: At most DEPTH words are returned per record. Further read requests produce no read-valid.
- R8: In single mode (single input high), the block stays done after the record has been read out, until an arm command is given.
- R9: In normal mode (single input low), the cycle after the last of the DEPTH reads is issued, the block restarts acquisition with the current pre-trigger length: status 1, or status 2 if that length is 0.
- R10: Status encoding is 0 idle, 1 filling pre-trigger, 2 armed, 3 post-trigger, 4 done. Arming goes to 1, or straight to 2 when the pre-trigger length is 0. Arm is honoured only in idle or done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_i | input | CH_W | Channel bank, one bit per channel |
| arm_i | input | 1 | Start or re-arm an acquisition |
| trig_i | input | 1 | Trigger pulse from the event detector |
| single_i | input | 1 | 1 = single mode, 0 = normal mode |
| pre_i | input | AW | Pre-trigger length, 0 to DEPTH-1 |
| rd_en_i | input | 1 | Read request for the next frozen word |
| rd_data_o | output | CH_W | Word returned by a read |
| rd_valid_o | output | 1 | rd_data_o holds a fresh word |
| done_o | output | 1 | Record is frozen |
| status_o | output | 3 | Current state code |
| trig_addr_o | output | AW | Memory address of the trigger sample |

## Verification
On every cycle the assertions check the following: status codes are legal, fill only moves on to armed, and the write pointer never moves while frozen. They also check that the trigger address captures the write pointer on the armed-to-post step, that read-valid only follows a frozen cycle, and that single mode holds done without an arm. Only the bench scenarios can show the content and order of a record. These are the exact post-trigger write count, the wrap-round after long armed waits, the edge positions of the pre-trigger length (0 and DEPTH-1), the read-count limit and the automatic restart in normal mode. The bench drives a known incrementing pattern into the channels to make this possible.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FILL  = 3'd1,
    ST_ARMED = 3'd2,
    ST_POST  = 3'd3,
    ST_DONE  = 3'd4
  } cap_state_e;
endpackage

// File: rtl/cap_mem.sv
module cap_mem #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          trig_i,
  input  logic          single_i,
  input  logic [AW-1:0] pre_i,
  input  logic          rd_last_i,
  output cap_state_e    state_o,
  output logic          we_o,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] taddr_o
);
  localparam logic [AW:0] DEPTH_C = DEPTH[AW:0];
  localparam logic [AW:0] ONE_C   = {{AW{1'b0}}, 1'b1};

  cap_state_e  state_q, state_n;
  logic [AW:0] cnt_q, cnt_n, pre_q, pre_n, post_len;
  logic [AW-1:0] wptr_q, wptr_n, taddr_q;
  logic        taddr_en, restart;

  assign post_len = DEPTH_C - pre_q;
  assign we_o     = (state_q == ST_FILL) || (state_q == ST_ARMED) || (state_q == ST_POST);
  assign restart  = ((state_q == ST_IDLE) && arm_i) ||
                    ((state_q == ST_DONE) && (arm_i || (!single_i && rd_last_i)));

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    pre_n    = pre_q;
    wptr_n   = wptr_q;
    taddr_en = 1'b0;
    if (we_o) wptr_n = wptr_q + 1'b1;
    case (state_q)
      ST_FILL: begin
        cnt_n = cnt_q + 1'b1;
        if (cnt_n == pre_q) state_n = ST_ARMED;
      end
      ST_ARMED: begin
        if (trig_i) begin
          taddr_en = 1'b1;
          cnt_n    = ONE_C;
          state_n  = (post_len == ONE_C) ? ST_DONE : ST_POST;
        end
      end
      ST_POST: begin
        cnt_n = cnt_q + 1'b1;
        if (cnt_n == post_len) state_n = ST_DONE;
      end
      ST_IDLE, ST_DONE: ;
      default: state_n = ST_IDLE;
    endcase
    if (restart) begin
      pre_n   = {1'b0, pre_i};
      cnt_n   = '0;
      wptr_n  = '0;
      state_n = (pre_i == '0) ? ST_ARMED : ST_FILL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pre_q   <= '0;
      wptr_q  <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      pre_q   <= pre_n;
      wptr_q  <= wptr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        taddr_q <= '0;
    else if (taddr_en) taddr_q <= wptr_q;
  end

  assign state_o = state_q;
  assign wptr_o  = wptr_q;
  assign taddr_o = taddr_q;
endmodule

// File: rtl/cap_reader.sv
module cap_reader #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frozen_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] base_i,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic          last_o,
  output logic          valid_o
);
  localparam logic [AW:0] DEPTH_C = DEPTH[AW:0];
  localparam logic [AW:0] LAST_C  = DEPTH_C - 1'b1;

  logic [AW:0] idx_q, idx_n;
  logic        valid_q;

  assign re_o    = frozen_i && rd_en_i && (idx_q != DEPTH_C);
  assign raddr_o = base_i + idx_q[AW-1:0];
  assign last_o  = re_o && (idx_q == LAST_C);

  always_comb begin
    idx_n = idx_q;
    if (!frozen_i)  idx_n = '0;
    else if (re_o)  idx_n = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      idx_q   <= idx_n;
      valid_q <= re_o;
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/cap_buffer.sv
module cap_buffer
  import cap_pkg::*;
#(
  parameter  int CH_W  = 8,
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CH_W-1:0] smp_i,
  input  logic            arm_i,
  input  logic            trig_i,
  input  logic            single_i,
  input  logic [AW-1:0]   pre_i,
  input  logic            rd_en_i,
  output logic [CH_W-1:0] rd_data_o,
  output logic            rd_valid_o,
  output logic            done_o,
  output logic [2:0]      status_o,
  output logic [AW-1:0]   trig_addr_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_ns;
  cap_state_e    state;
  logic          wr_en, rd_re, rd_last;
  logic [AW-1:0] wr_ptr, rd_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  cap_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_ns), .arm_i(arm_i), .trig_i(trig_i),
    .single_i(single_i), .pre_i(pre_i), .rd_last_i(rd_last),
    .state_o(state), .we_o(wr_en), .wptr_o(wr_ptr), .taddr_o(trig_addr_o)
  );

  cap_reader #(.DEPTH(DEPTH), .AW(AW)) u_reader (
    .clk(clk), .rst_n(rst_ns), .frozen_i(done_o), .rd_en_i(rd_en_i),
    .base_i(wr_ptr), .re_o(rd_re), .raddr_o(rd_addr), .last_o(rd_last),
    .valid_o(rd_valid_o)
  );

  cap_mem #(.W(CH_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wr_ptr), .wdata(smp_i),
    .re(rd_re), .raddr(rd_addr), .rdata(rd_data_o)
  );

  assign done_o   = (state == ST_DONE);
  assign status_o = state;
endmodule

// File: rtl/cap_buffer_chk.sv
module cap_buffer_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    status_o,
  input logic          done_o,
  input logic          rd_valid_o,
  input logic [AW-1:0] trig_addr_o,
  input logic          single_i,
  input logic          arm_i,
  input logic [AW-1:0] wr_ptr
);
  a_r10_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    status_o <= 3'd4);

  a_r3_fill_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == 3'd1) |=> (status_o == 3'd1 || status_o == 3'd2));

  a_r4_frozen_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(done_o)) |-> (wr_ptr == $past(wr_ptr)));

  a_r5_trig_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_o) == 3'd2 && (status_o == 3'd3 || status_o == 3'd4))
      |-> (trig_addr_o == $past(wr_ptr)));

  a_r6_valid_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(done_o));

  a_r8_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (single_i && done_o && !arm_i) |=> done_o);
endmodule

bind cap_buffer cap_buffer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_ns), .status_o(status_o), .done_o(done_o),
  .rd_valid_o(rd_valid_o), .trig_addr_o(trig_addr_o), .single_i(single_i),
  .arm_i(arm_i), .wr_ptr(wr_ptr)
);

// File: tb/cap_buffer_tb.sv
module cap_buffer_tb;
  localparam int CH_W  = 8;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_i = 1'b0, trig_i = 1'b0, single_i = 1'b1, rd_en_i = 1'b0;
  logic [AW-1:0]   pre_i = '0;
  logic [CH_W-1:0] smp_i;
  logic [CH_W-1:0] rd_data_o;
  logic            rd_valid_o, done_o;
  logic [2:0]      status_o;
  logic [AW-1:0]   trig_addr_o;
  logic [31:0]     cyc = 0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [CH_W-1:0] exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign smp_i = cyc[CH_W-1:0];

  cap_buffer #(.CH_W(CH_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .arm_i(arm_i), .trig_i(trig_i),
    .single_i(single_i), .pre_i(pre_i), .rd_en_i(rd_en_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .done_o(done_o),
    .status_o(status_o), .trig_addr_o(trig_addr_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Monitor: pops the scoreboard as read words appear
  always @(negedge clk) begin
    if (rst_n && rd_valid_o) begin
      if (exp_q.size() == 0) check(1'b0, "R7 unexpected word", int'(rd_data_o), -1);
      else begin
        logic [CH_W-1:0] e;
        e = exp_q.pop_front();
        check(rd_data_o == e, "R6/R2 readout order", int'(rd_data_o), int'(e));
      end
    end
  end

  task automatic run_capture(input int pre, input bit single, input int delay,
                             input bit early, input bit do_arm);
    int nwr = 0, waited = 0, n_post = 1, taddr_exp;
    logic [CH_W-1:0] vt;
    single_i = single;
    if (do_arm) begin
      @(negedge clk);
      pre_i = pre[AW-1:0];
      arm_i = 1'b1;
      @(negedge clk);
      arm_i = 1'b0;
      check(status_o == ((pre == 0) ? 3'd2 : 3'd1), "R10 arm state", int'(status_o),
            (pre == 0) ? 2 : 1);
    end
    while (!(status_o == 3'd2 && waited >= delay)) begin
      if (status_o == 3'd2) waited++;
      trig_i = early && (status_o == 3'd1);
      nwr++;
      @(negedge clk);
      if (trig_i) check(status_o == 3'd1 || status_o == 3'd2, "R3 trigger in fill",
                        int'(status_o), 1);
      trig_i = 1'b0;
      if (nwr > 1000) break;
    end
    vt = smp_i;
    taddr_exp = nwr % DEPTH;
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    check(status_o == ((DEPTH - pre == 1) ? 3'd4 : 3'd3), "R4 state after trigger",
          int'(status_o), (DEPTH - pre == 1) ? 4 : 3);
    while (status_o == 3'd3 && n_post < 100) begin
      n_post++;
      @(negedge clk);
    end
    check(n_post == DEPTH - pre, "R4 post-trigger writes", n_post, DEPTH - pre);
    check(done_o == 1'b1, "R6 done flag", int'(done_o), 1);
    check(int'(trig_addr_o) == taddr_exp, "R5 trigger address", int'(trig_addr_o), taddr_exp);
    for (int k = 0; k < DEPTH; k++) exp_q.push_back(vt - CH_W'(pre) + CH_W'(k));
    for (int k = 0; k < DEPTH; k++) begin
      rd_en_i = 1'b1;
      @(negedge clk);
    end
    rd_en_i = 1'b0;
    if (single) begin
      check(status_o == 3'd4, "R8 single holds done", int'(status_o), 4);
      @(negedge clk);
      check(exp_q.size() == 0, "R6 all words returned", exp_q.size(), 0);
      rd_en_i = 1'b1;
      @(negedge clk);
      rd_en_i = 1'b0;
      @(negedge clk);
      check(rd_valid_o == 1'b0, "R7 extra read ignored", int'(rd_valid_o), 0);
      repeat (3) @(negedge clk);
      check(status_o == 3'd4, "R8 still done", int'(status_o), 4);
    end else begin
      check(status_o == ((pre == 0) ? 3'd2 : 3'd1), "R9 normal restart", int'(status_o),
            (pre == 0) ? 2 : 1);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(status_o == 3'd0 && !done_o && !rd_valid_o, "R1 reset state", int'(status_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(status_o == 3'd0 && !done_o, "R1 idle after reset", int'(status_o), 0);
    run_capture(8, 1'b1, 3, 1'b0, 1'b1);    // mid-record trigger
    run_capture(15, 1'b1, 0, 1'b1, 1'b1);   // early trigger ignored, direct to done
    run_capture(4, 1'b0, 40, 1'b0, 1'b1);   // long wrap, normal restart
    run_capture(4, 1'b1, 2, 1'b0, 1'b0);    // capture after automatic restart
    run_capture(0, 1'b0, 5, 1'b0, 1'b1);    // no pre-trigger words, restart to armed
    repeat (2) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule